// File: doc/BRIEF.md
# Dual-Clock Half-Word Packing FIFO with Early-Full Reserve

This block moves data from one clock domain into another and doubles its width on the way. A producer offers 18-bit half-words under a valid/ready handshake in the write clock domain. Each pair of accepted half-words becomes one 36-bit entry in a 512-entry dual-port store. A consumer in the read clock domain takes the 36-bit words under its own valid/ready handshake. The read side works in fall-through mode: the oldest word is presented and flagged valid as soon as it has crossed, before the consumer asks for it.

An early-full flag serves a producer that feeds the FIFO from a pipelined memory reader. That producer may still have several read results in flight when it decides to stop issuing requests. The flag rises at 1017 stored half-words, which leaves 7 half-word slots for the results that are still arriving. Pointers cross between the domains as Gray codes through two-flop synchronisers. The full, early-full and empty views are therefore conservative: each side may see the other side's progress a few cycles late, but it never sees progress that has not happened.

Each domain has its own synchronous active-low reset, which clears only that domain's pointers and flags.

Top module: `hwpack_fifo`

## Requirements
- R1: While the write reset is held and after it is released, wr_full is 0, wr_prog_full is 0 and wr_ready is 1. While the read reset is held, rd_valid is 0 and rd_empty is 1.
- R2: Two consecutive accepted half-words form one entry. The earlier half-word is placed in rd_data[35:18] and the later one in rd_data[17:0].
- R3: Once a complete entry is stored, rd_valid rises and rd_data carries that entry without rd_ready ever being high.
- R4: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data stays unchanged on the next read clock.
- R5: wr_prog_full is 1 exactly when the write-side occupancy is 1017 half-words or more. Write-side occupancy is twice the stored entries not yet known to be read, plus one for a pending unpaired half-word. With the reader idle, the flag is 0 after 1016 accepted half-words and 1 after 1017.
- R6: wr_full is 1 and wr_ready is 0 when the write side counts 512 stored entries (1024 half-words). A half-word offered while wr_full is 1 is not stored: it never appears at the read port, and the pointers do not move.
- R7: Every accepted half-word pair is delivered exactly once, in order, under any pattern of wr_valid and rd_ready stalls. A word leaves the output only in a read cycle with rd_valid and rd_ready both 1.
- R8: rd_ready held high while rd_valid is 0 has no effect. No word is produced, and the next stored word is the next one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain synchronous reset, active low |
| wr_data | input | 18 | Half-word offered by the producer |
| wr_valid | input | 1 | Producer has a half-word on wr_data |
| wr_ready | output | 1 | FIFO can accept a half-word this cycle |
| wr_full | output | 1 | All 512 entries are taken, as the write side sees it |
| wr_prog_full | output | 1 | Occupancy has reached the early-full level |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain synchronous reset, active low |
| rd_data | output | 36 | Oldest stored word, upper half written first |
| rd_valid | output | 1 | rd_data holds a word |
| rd_ready | input | 1 | Consumer takes the word this cycle |
| rd_empty | output | 1 | No word is offered at the read port |

## Verification
A write pointer or pairing flag that went wrong would show at the read port as a swapped half, a repeated word or a missing word. It would appear on the first word delivered after the fault, which is within a few read cycles of the crossing. A wrong occupancy count would move the early-full or full edge away from the 1017th or 1024th half-word. It shows on the write clock right after that write. A faulty output register shows as data changing under a stall on the very next read edge. The long stall-heavy random phase is there to bring such faults out.

// File: rtl/hwpack_pkg.sv
// Package: default dimensions shared by the packing FIFO and its checker.
// Assumes: the read word is always two write half-words wide.
package hwpack_pkg;
    localparam int HALF_W_DEF      = 18;    // write port width
    localparam int ADDR_W_DEF      = 9;     // log2 of stored entries
    localparam int PFULL_LEVEL_DEF = 1017;  // half-words at which early-full rises
    localparam int SYNC_STAGES_DEF = 2;     // flops per pointer crossing
endpackage

// File: rtl/hwpack_gray_sync.sv
// Module: carries a Gray-coded pointer into the local clock domain through a
// chain of flops, then converts it to binary for the local arithmetic.
// Assumes: the source changes the pointer by at most one Gray step per
// source clock, so every sampled value is a real pointer value.
module hwpack_gray_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the foreign-domain pointer.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= gray_in;
                end
            end else begin : g_next
                // Later flops let metastability resolve.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    // Gray-to-binary: each bit is the XOR of all Gray bits at or above it.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ stage[STAGES-1][i];
            bin_out[i] = acc;
        end
    end
endmodule

// File: rtl/hwpack_store.sv
// Module: dual-port store, written on the write clock and read combinationally
// at the address held by the read side.
// Assumes: a slot is never read while it is being written; the pointer
// protocol guarantees this.
module hwpack_store #(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];

    // Store one completed entry.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hwpack_wr_side.sv
// Module: write domain. Pairs accepted half-words into entries, advances the
// write pointer, and derives full and early-full from the synchronised read
// pointer.
// Assumes: the read pointer arrives Gray-coded from the other domain. The
// flags are conservative because that pointer lags.
module hwpack_wr_side #(
    parameter int HALF_W      = 18,
    parameter int AW          = 9,
    parameter int PFULL_LEVEL = 1017,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HALF_W-1:0]   in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                full,
    output logic                prog_full,
    output logic [AW+1:0]       occ,
    input  logic [AW:0]         rd_gray_async,
    output logic [AW:0]         wr_gray,
    output logic                mem_we,
    output logic [AW-1:0]       mem_waddr,
    output logic [2*HALF_W-1:0] mem_wdata
);
    localparam int PW    = AW + 1;
    localparam int OCC_W = AW + 2;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0]     wbin;
    logic [PW-1:0]     wbin_inc;
    logic [PW-1:0]     rd_bin_s;
    logic [PW-1:0]     entries;
    logic [HALF_W-1:0] upper_q;
    logic              half_q;
    logic              accept;
    logic              complete;

    hwpack_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (rd_gray_async),
        .bin_out (rd_bin_s)
    );

    // Occupancy and flags, seen from the write side.
    always_comb begin
        entries   = wbin - rd_bin_s;
        full      = (entries == PW'(DEPTH));
        occ       = {entries, half_q};
        prog_full = (occ >= OCC_W'(PFULL_LEVEL));
        in_ready  = !full;
        accept    = in_valid && !full;
        complete  = accept && half_q;
        wbin_inc  = wbin + PW'(1);
    end

    assign mem_we    = complete;
    assign mem_waddr = wbin[AW-1:0];
    assign mem_wdata = {upper_q, in_data};

    // Pointer and pairing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wr_gray <= '0;
            half_q  <= 1'b0;
        end else if (accept) begin
            half_q <= !half_q;
            if (complete) begin
                wbin    <= wbin_inc;
                wr_gray <= wbin_inc ^ (wbin_inc >> 1);
            end
        end
    end

    // Hold the first half of a pair until its partner arrives.
    always_ff @(posedge clk) begin
        if (accept && !half_q) upper_q <= in_data;
    end
endmodule

// File: rtl/hwpack_rd_side.sv
// Module: read domain. Keeps a fall-through output register that is filled
// from the store whenever it is empty or being emptied, and advances the read
// pointer on each fill.
// Assumes: the write pointer arrives Gray-coded from the other domain, so the
// empty view lags and is conservative.
module hwpack_rd_side #(
    parameter int DW          = 36,
    parameter int AW          = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   wr_gray_async,
    output logic [AW:0]   rd_gray,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_inc;
    logic [PW-1:0] wr_bin_s;
    logic          store_empty;
    logic          load;

    hwpack_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (wr_gray_async),
        .bin_out (wr_bin_s)
    );

    // Decide whether the output register takes the next stored word.
    always_comb begin
        store_empty = (rbin == wr_bin_s);
        load        = !store_empty && (!out_valid || out_ready);
        rbin_inc    = rbin + PW'(1);
    end

    assign mem_raddr = rbin[AW-1:0];

    // Read pointer and output valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin      <= '0;
            rd_gray   <= '0;
            out_valid <= 1'b0;
        end else if (load) begin
            rbin      <= rbin_inc;
            rd_gray   <= rbin_inc ^ (rbin_inc >> 1);
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Output data register, loaded together with the pointer advance.
    always_ff @(posedge clk) begin
        if (rst_n && load) out_data <= mem_rdata;
    end
endmodule

// File: rtl/hwpack_fifo.sv
// Module: top of the dual-clock packing FIFO. Wires the write side, the
// store and the read side, and exchanges Gray pointers between the domains.
// Assumes: the two clocks are unrelated. Each reset is synchronous to its own
// clock, and the two resets are applied together whenever the FIFO is emptied.
module hwpack_fifo #(
    parameter int HALF_W      = hwpack_pkg::HALF_W_DEF,
    parameter int ADDR_W      = hwpack_pkg::ADDR_W_DEF,
    parameter int PFULL_LEVEL = hwpack_pkg::PFULL_LEVEL_DEF,
    parameter int SYNC_STAGES = hwpack_pkg::SYNC_STAGES_DEF
) (
    input  logic                wr_clk,
    input  logic                wr_rst_n,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                wr_valid,
    output logic                wr_ready,
    output logic                wr_full,
    output logic                wr_prog_full,
    input  logic                rd_clk,
    input  logic                rd_rst_n,
    output logic [2*HALF_W-1:0] rd_data,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic                rd_empty
);
    localparam int DW = 2 * HALF_W;

    logic [ADDR_W:0]   wr_gray;
    logic [ADDR_W:0]   rd_gray;
    logic [ADDR_W+1:0] wr_occ;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DW-1:0]     mem_wdata;
    logic [DW-1:0]     mem_rdata;

    hwpack_wr_side #(
        .HALF_W(HALF_W), .AW(ADDR_W),
        .PFULL_LEVEL(PFULL_LEVEL), .SYNC_STAGES(SYNC_STAGES)
    ) u_wr (
        .clk           (wr_clk),
        .rst_n         (wr_rst_n),
        .in_data       (wr_data),
        .in_valid      (wr_valid),
        .in_ready      (wr_ready),
        .full          (wr_full),
        .prog_full     (wr_prog_full),
        .occ           (wr_occ),
        .rd_gray_async (rd_gray),
        .wr_gray       (wr_gray),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata)
    );

    hwpack_store #(.AW(ADDR_W), .DW(DW)) u_store (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    hwpack_rd_side #(.DW(DW), .AW(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk           (rd_clk),
        .rst_n         (rd_rst_n),
        .wr_gray_async (wr_gray),
        .rd_gray       (rd_gray),
        .mem_raddr     (mem_raddr),
        .mem_rdata     (mem_rdata),
        .out_data      (rd_data),
        .out_valid     (rd_valid),
        .out_ready     (rd_ready)
    );

    assign rd_empty = !rd_valid;
endmodule

// File: rtl/hwpack_fifo_chk.sv
// Module: assertion checker bound to the packing FIFO top.
// Assumes: each property is disabled while its own domain is in reset.
module hwpack_fifo_chk #(
    parameter int DW     = 36,
    parameter int ADDR_W = 9
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_full,
    input logic              wr_prog_full,
    input logic [ADDR_W+1:0] wr_occ,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic [DW-1:0]     rd_data,
    input logic              rd_valid,
    input logic              rd_ready
);
    localparam int CAP_HW = 2 << ADDR_W;

    // R4
    hold_stable_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R7
    drop_on_accept_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(rd_valid) |-> $past(rd_ready));

    // R5
    pfull_before_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_full |-> wr_prog_full);

    // R6
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_occ <= (ADDR_W+2)'(CAP_HW));
endmodule

bind hwpack_fifo hwpack_fifo_chk #(.DW(2*HALF_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .wr_full      (wr_full),
    .wr_prog_full (wr_prog_full),
    .wr_occ       (wr_occ),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready)
);

// File: tb/hwpack_fifo_tb.sv
`timescale 1ns/1ps
// Bench: directed fill, threshold and drain cases, then a seeded random phase
// with stalls on both sides against a queue of expected words.
module hwpack_fifo_tb;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic [17:0] wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        rd_ready = 1'b0;
    logic        wr_ready, wr_full, wr_prog_full, rd_valid, rd_empty;
    logic [35:0] rd_data;

    int          n_chk = 0;
    int          n_err = 0;
    bit          finished = 1'b0;
    logic [35:0] exp_q[$];

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    hwpack_fifo u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_full(wr_full),
        .wr_prog_full(wr_prog_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_empty(rd_empty)
    );

    // Record one check; report on failure.
    task automatic chk(input bit ok, input string tag,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected word for a pair of half-words, earlier one on top.
    function automatic logic [35:0] pair_of(input logic [17:0] a, input logic [17:0] b);
        return {a, b};
    endfunction

    // Offer one half-word until it is accepted.
    task automatic push_hw(input logic [17:0] d);
        bit done;
        done = 1'b0;
        while (!done) begin
            @(negedge wr_clk);
            wr_data  = d;
            wr_valid = 1'b1;
            done     = wr_ready;
        end
    endtask

    // Drop wr_valid after the accepting edge.
    task automatic wr_idle();
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    // Take one word with rd_ready high and compare it with the queue head.
    task automatic pop_expect(input string tag);
        bit got;
        got = 1'b0;
        for (int k = 0; k < 200 && !got; k++) begin
            @(negedge rd_clk);
            rd_ready = 1'b1;
            if (rd_valid) begin
                chk(exp_q.size() > 0 && rd_data == exp_q[0], tag, rd_data,
                    exp_q.size() > 0 ? exp_q[0] : 36'h0);
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                got = 1'b1;
            end
        end
        if (!got) chk(1'b0, {tag, " no word"}, 36'h0, 36'h1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge wr_clk);
        chk(1'b0, "watchdog", 36'h0, 36'h1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge wr_clk);
        // R1: flags while held in reset
        chk(!wr_full && !wr_prog_full && wr_ready, "R1 in reset", {wr_full, wr_prog_full, wr_ready}, 36'h1);
        chk(!rd_valid && rd_empty, "R1 read reset", {rd_valid, rd_empty}, 36'h1);
        wr_rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
        chk(!wr_full && !wr_prog_full && wr_ready, "R1 after release", {wr_full, wr_prog_full, wr_ready}, 36'h1);

        // Fill with the reader held in reset, so occupancy equals writes.
        for (int i = 0; i < 1016; i++) begin
            push_hw(18'(i));
            if (i % 2 == 1) exp_q.push_back(pair_of(18'(i - 1), 18'(i)));
        end
        wr_idle();
        chk(!wr_prog_full, "R5 at 1016", {35'h0, wr_prog_full}, 36'h0);
        push_hw(18'(1016));
        wr_idle();
        chk(wr_prog_full && !wr_full, "R5 at 1017", {wr_prog_full, wr_full}, 36'h2);
        for (int i = 1017; i < 1023; i++) begin
            push_hw(18'(i));
            if (i % 2 == 1) exp_q.push_back(pair_of(18'(i - 1), 18'(i)));
        end
        wr_idle();
        chk(!wr_full && wr_ready, "R6 at 1023", {wr_full, wr_ready}, 36'h1);
        push_hw(18'(1023));
        exp_q.push_back(pair_of(18'(1022), 18'(1023)));
        wr_idle();
        chk(wr_full && !wr_ready, "R6 at 1024", {wr_full, wr_ready}, 36'h2);
        // R6: offers while full must be dropped
        for (int k = 0; k < 4; k++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            wr_data  = 18'h2AAAA;
            chk(!wr_ready && wr_full, "R6 offer while full", {wr_ready, wr_full}, 36'h1);
        end
        wr_idle();

        // Drain everything; the first word checks the half order.
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
        pop_expect("R2 first pair order");
        for (int k = 1; k < 512; k++) pop_expect("R7 drain");
        // R6 and R8: nothing more arrives while rd_ready stays high
        for (int k = 0; k < 20; k++) begin
            @(negedge rd_clk);
            rd_ready = 1'b1;
            if (k % 5 == 4) chk(!rd_valid && rd_empty, "R6 R8 no extra word", {rd_valid, rd_empty}, 36'h1);
        end
        chk(!wr_full && !wr_prog_full, "R6 flags clear after drain", {wr_full, wr_prog_full}, 36'h0);

        // R8: a word written after an empty interval with ready high
        push_hw(18'h00F0F);
        push_hw(18'h3C3C3);
        exp_q.push_back(pair_of(18'h00F0F, 18'h3C3C3));
        wr_idle();
        pop_expect("R8 next word after empty reads");
        repeat (10) @(negedge rd_clk);
        chk(!rd_valid, "R8 not duplicated", {35'h0, rd_valid}, 36'h0);

        // R3: fall-through without ready, then R4 hold
        @(negedge rd_clk);
        rd_ready = 1'b0;
        push_hw(18'h12345);
        push_hw(18'h00ABC);
        exp_q.push_back(pair_of(18'h12345, 18'h00ABC));
        wr_idle();
        repeat (12) @(negedge rd_clk);
        chk(rd_valid && rd_data == exp_q[0], "R3 fall-through", rd_data, exp_q[0]);
        for (int k = 0; k < 5; k++) begin
            @(negedge rd_clk);
            chk(rd_valid && rd_data == exp_q[0], "R4 hold while stalled", rd_data, exp_q[0]);
        end
        pop_expect("R3 take presented word");

        // R7: random traffic on both sides
        fork
            begin : writer
                logic [17:0] first_h;
                int n;
                n = 0;
                first_h = '0;
                while (n < 2000) begin
                    logic [17:0] d;
                    bit v;
                    @(negedge wr_clk);
                    v = ($urandom % 10) < 7;
                    d = 18'($urandom);
                    wr_valid = v;
                    wr_data  = d;
                    if (v && wr_ready) begin
                        if (n % 2 == 1) exp_q.push_back(pair_of(first_h, d));
                        else            first_h = d;
                        n++;
                    end
                end
                wr_idle();
            end
            begin : reader
                int got, stall;
                bit pv, pr, r;
                logic [35:0] pd;
                got = 0; stall = 0; pv = 0; pr = 0; pd = '0;
                while (got < 1000) begin
                    @(negedge rd_clk);
                    if (stall > 0) begin
                        r = 1'b0;
                        stall--;
                    end else begin
                        r = ($urandom % 4) != 0;
                        if ($urandom % 16 == 0) stall = 3 + int'($urandom % 6);
                    end
                    rd_ready = r;
                    if (pv && !pr)
                        chk(rd_valid && rd_data == pd, "R4 random stall hold", rd_data, pd);
                    if (rd_valid && r) begin
                        chk(exp_q.size() > 0 && rd_data == exp_q[0], "R7 random order",
                            rd_data, exp_q.size() > 0 ? exp_q[0] : 36'h0);
                        if (exp_q.size() > 0) void'(exp_q.pop_front());
                        got++;
                    end
                    pv = rd_valid;
                    pr = r;
                    pd = rd_data;
                end
            end
        join
        repeat (20) @(negedge rd_clk);
        chk(exp_q.size() == 0 && !rd_valid, "R7 all delivered once", 36'(exp_q.size()), 36'h0);
        finish_run();
    end
endmodule